// File: doc/BRIEF.md
# Serial Codec Frame Transmitter (Master)

This block drives a synchronous serial codec link as the clock master. It divides its master clock down to a bit clock, marks the start of each frame with an active-high sync pulse one bit period long, and sends a fixed number of 16-bit words in every frame, least significant bit first. The frame length is set in bit clocks and need not equal the number of words times the word width. Any bit periods left after the last word carry zeros.

Words are taken from a 64-byte transmit FIFO that is filled through a byte-wide valid/ready stream. The FIFO accepts a byte on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high while the FIFO has free space, and a producer that sees it low must hold its byte until it rises again. Each word is built from two consecutive bytes, low byte first. A FIFO alarm level drives a transmit-ready interrupt that can be masked. Software sets the enable, frame length, clock divider, alarm level and interrupt mask through a plain write/read register port. It should disable transmission while it reconfigures the block.

Top module: `codec_frame_tx`

## Requirements
- R1: After reset, `bclk`, `fsync`, `sdata` and `irq` are 0 and `in_ready` is 1. The registers read back as: enable 0, frame length 52, half divider 2, alarm 16, mask 0, level 0.
- R2: While enabled, `bclk` spends half-divider master cycles high and the same number low, so the bit period is 2 × half divider cycles. The default gives 4 cycles.
- R3: `fsync` is high for exactly one bit period at the start of each frame. Successive rising edges of `fsync` are frame-length bit periods apart.
- R4: `fsync` and `sdata` change only on master cycles where `bclk` rises, except when the block is disabled. The first data bit goes out in the bit period where `fsync` is high.
- R5: Each frame carries three word slots of 16 bits, each sent LSB first. Each word is made from two FIFO bytes, with the earlier byte as bits 7:0.
- R6: For a frame length of at least 48, the bit periods from 48 up to the frame length minus one carry `sdata` = 0.
- R7: If the FIFO holds fewer than two bytes when a word slot begins, the slot sends 16 zeros and a sticky underrun flag is set (CTRL bit 1). Frame timing is unchanged. Writing CTRL with bit 1 set clears the flag.
- R8: `in_ready` is 1 exactly when the FIFO level is below 64. A byte offered while the level is 64 is not stored, and the level stays at 64.
- R9: `irq` is 1 exactly when the enable bit, the mask bit and the condition (level ≤ alarm) all hold.
- R10: With the enable bit at 0, `bclk`, `fsync` and `sdata` stay at 0.
- R11: Register map, addressed by `reg_addr`:
  - 0: CTRL. Bit 0 is enable (read/write). Bit 1 reads the underrun flag and clears it on a write of 1.
  - 1: frame length in bit clocks, 8 bits.
  - 2: half divider, 8 bits.
  - 3: alarm level, 7 bits.
  - 4: mask, bit 0.
  - 5: FIFO level in bytes, read only.

  Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | FIFO can accept a byte |
| in_data | input | 8 | Byte stream data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from address) |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync, active high |
| sdata | output | 1 | Serial data |
| irq | output | 1 | Transmit-ready interrupt |

## Verification
A stream byte can be accepted in the same master cycle in which a word slot removes two bytes, so the FIFO level moves by +1 and −2 at once. The bench provokes this by enabling the block with only two words queued and then streaming four more words while the first slots are loading. It judges the result by checking that every word comes out intact and in order and that no underrun appears until the queue runs dry. It also checks the interrupt against the level readback while the FIFO drains through the alarm threshold.

// File: rtl/cft_pkg.sv
package cft_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int BYTE_W     = 8;
  localparam int WORDS_PER_FRAME = 3;
  localparam int LEN_W      = 8;
  localparam int DIV_W      = 8;
  localparam int REG_W      = 16;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_LEN   = 3'd1,
    A_DIV   = 3'd2,
    A_ALARM = 3'd3,
    A_MASK  = 3'd4,
    A_LEVEL = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/cft_fifo.sv
module cft_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop2,
  output logic [DW-1:0]              dout0,
  output logic [DW-1:0]              dout1,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] level_n;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_comb begin
    level_n = level + LW'(push);
    if (pop2) level_n = level_n - LW'(2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop2) rp <= rp + AW'(2);
      level <= level_n;
    end
  end

  assign dout0 = mem[rp];
  assign dout1 = mem[rp + AW'(1)];
  assign full  = (level == LW'(DEPTH));
endmodule

// File: rtl/cft_bitclk.sv
module cft_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             bclk,
  output logic             rise
);
  logic [DIV_W-1:0] cnt;
  logic             last;

  // half of 0 behaves as 1
  assign last = ({1'b0, cnt} + (DIV_W+1)'(1)) >= {1'b0, half};
  assign rise = en && last && !bclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (last) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/cft_framer.sv
module cft_framer #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 3,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise,
  input  logic [LEN_W-1:0]  len,
  input  logic              avail,
  input  logic [WORD_W-1:0] word_in,
  output logic              pop,
  output logic              underrun,
  output logic              fsync,
  output logic              sdata
);
  localparam int WB_W = $clog2(WORD_W);
  localparam int WI_W = $clog2(NWORDS+1);

  logic              running;
  logic [LEN_W-1:0]  bitpos, n_bitpos;
  logic [WB_W-1:0]   wbit, n_wbit;
  logic [WI_W-1:0]   widx, n_widx;
  logic [WORD_W-1:0] shreg;
  logic              start, in_word, word_start;

  always_comb begin
    start    = !running || (({1'b0, bitpos} + (LEN_W+1)'(1)) >= {1'b0, len});
    n_bitpos = bitpos;
    n_wbit   = wbit;
    n_widx   = widx;
    if (start) begin
      n_bitpos = '0;
      n_wbit   = '0;
      n_widx   = '0;
    end else begin
      n_bitpos = bitpos + LEN_W'(1);
      if (widx < WI_W'(NWORDS)) begin
        if (wbit == WB_W'(WORD_W-1)) begin
          n_wbit = '0;
          n_widx = widx + WI_W'(1);
        end else begin
          n_wbit = wbit + WB_W'(1);
        end
      end
    end
    in_word    = (n_widx < WI_W'(NWORDS));
    word_start = in_word && (n_wbit == '0);
  end

  assign pop      = rise && word_start && avail;
  assign underrun = rise && word_start && !avail;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      running <= 1'b0;
      bitpos  <= '0;
      wbit    <= '0;
      widx    <= '0;
      shreg   <= '0;
      fsync   <= 1'b0;
      sdata   <= 1'b0;
    end else if (rise) begin
      running <= 1'b1;
      bitpos  <= n_bitpos;
      wbit    <= n_wbit;
      widx    <= n_widx;
      fsync   <= start;
      if (word_start) begin
        if (avail) begin
          sdata <= word_in[0];
          shreg <= word_in >> 1;
        end else begin
          sdata <= 1'b0;
          shreg <= '0;
        end
      end else if (in_word) begin
        sdata <= shreg[0];
        shreg <= shreg >> 1;
      end else begin
        sdata <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/codec_frame_tx.sv
module codec_frame_tx
  import cft_pkg::*;
#(
  parameter int DEPTH    = FIFO_DEPTH,
  parameter int BW       = BYTE_W,
  parameter int NWORDS   = WORDS_PER_FRAME,
  parameter int LW       = LEN_W,
  parameter int DW       = DIV_W,
  parameter int RW       = REG_W,
  parameter int LEN_RST  = 52,
  parameter int DIV_RST  = 2,
  parameter int ALM_RST  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_data,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          bclk,
  output logic          fsync,
  output logic          sdata,
  output logic          irq
);
  localparam int WORD_W = 2 * BW;
  localparam int LVL_W  = $clog2(DEPTH+1);

  logic             tx_en, irq_mask, underrun_q;
  logic [LW-1:0]    frame_len;
  logic [DW-1:0]    half_div;
  logic [LVL_W-1:0] alarm_q, fifo_level;
  logic             fifo_full, push, pop2, avail, rise, underrun_p;
  logic [BW-1:0]    b0, b1;
  logic             clr_under;

  assign in_ready  = !fifo_full;
  assign push      = in_valid && !fifo_full;
  assign avail     = fifo_level >= LVL_W'(2);
  assign clr_under = reg_wr && (reg_addr == A_CTRL) && reg_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en      <= 1'b0;
      irq_mask   <= 1'b0;
      underrun_q <= 1'b0;
      frame_len  <= LW'(LEN_RST);
      half_div   <= DW'(DIV_RST);
      alarm_q    <= LVL_W'(ALM_RST);
    end else begin
      underrun_q <= underrun_p || (underrun_q && !clr_under);
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:  tx_en     <= reg_wdata[0];
          A_LEN:   frame_len <= reg_wdata[LW-1:0];
          A_DIV:   half_div  <= reg_wdata[DW-1:0];
          A_ALARM: alarm_q   <= reg_wdata[LVL_W-1:0];
          A_MASK:  irq_mask  <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = RW'({underrun_q, tx_en});
      A_LEN:   reg_rdata = RW'(frame_len);
      A_DIV:   reg_rdata = RW'(half_div);
      A_ALARM: reg_rdata = RW'(alarm_q);
      A_MASK:  reg_rdata = RW'(irq_mask);
      A_LEVEL: reg_rdata = RW'(fifo_level);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = tx_en && irq_mask && (fifo_level <= alarm_q);

  cft_fifo #(.DEPTH(DEPTH), .DW(BW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(in_data), .pop2(pop2),
    .dout0(b0), .dout1(b1), .level(fifo_level), .full(fifo_full)
  );

  cft_bitclk #(.DIV_W(DW)) u_bclk (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .half(half_div),
    .bclk(bclk), .rise(rise)
  );

  cft_framer #(.WORD_W(WORD_W), .NWORDS(NWORDS), .LEN_W(LW)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .rise(rise), .len(frame_len),
    .avail(avail), .word_in({b1, b0}), .pop(pop2), .underrun(underrun_p),
    .fsync(fsync), .sdata(sdata)
  );
endmodule

// File: rtl/cft_checker.sv
module cft_checker #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk,
  input logic             fsync,
  input logic             sdata,
  input logic             irq,
  input logic             in_ready,
  input logic             tx_en,
  input logic [LVL_W-1:0] level,
  input logic [LVL_W-1:0] alarm
);
  // R3: sync edges only at a bit clock rise
  a_r3_fsync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $rose(bclk));
  a_r3_fsync_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fsync) && tx_en) |-> $rose(bclk));
  // R4: data moves only with a bit clock rise while running
  a_r4_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && !$stable(sdata)) |-> $rose(bclk));
  // R10: idle outputs low when disabled
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !$past(tx_en)) |-> (!bclk && !fsync && !sdata));
  // R8: full FIFO stalls the stream, level bounded
  a_r8_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) |-> !in_ready);
  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  // R9: no interrupt above the alarm level
  a_r9_quiet_above: assert property (@(posedge clk) disable iff (!rst_n)
    (level > alarm) |-> !irq);
endmodule

bind codec_frame_tx cft_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdata(sdata),
  .irq(irq), .in_ready(in_ready), .tx_en(tx_en), .level(fifo_level),
  .alarm(alarm_q)
);

// File: tb/sim_codec_frame_tx.sv
module sim_codec_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bclk, fsync, sdata, irq;

  always #4 clk = ~clk;

  codec_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bclk(bclk),
    .fsync(fsync), .sdata(sdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  int  exp_len  = 52;
  int  exp_half = 2;
  bit  mon_on   = 1'b0;
  int  zero_slots = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // driver: queue expected word, stream low byte then high byte
  task automatic push_word(input logic [15:0] w);
    exp_q.push_back(w);
    push_byte(w[7:0]);
    push_byte(w[15:8]);
  endtask

  // monitor: sample at falling master edge after each bit clock rise
  logic        prev_b = 1'b0;
  int          pos = 0;
  int          since = 0;
  bit          synced = 1'b0;
  logic [15:0] acc = '0;
  always @(negedge clk) begin
    since++;
    if (!mon_on) synced = 1'b0;
    if (mon_on && bclk && !prev_b) begin
      if (synced) chk("R2", "bit period cycles", since, 2 * exp_half);
      since = 0;
      if (fsync) begin
        if (synced) chk("R3", "frame length", pos + 1, exp_len);
        pos = 0;
        synced = 1'b1;
      end else begin
        pos++;
      end
      if (synced) begin
        if (pos < 48) begin
          acc[pos % 16] = sdata;
          if (pos % 16 == 15) begin
            logic [15:0] e;
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else begin e = '0; zero_slots++; end
            chk("R5", "word LSB-first", int'(acc), int'(e));
          end
        end else begin
          chk("R6", "pad bit", int'(sdata), 0);
        end
      end
    end
    prev_b = bclk;
  end

  task automatic run();
    logic [15:0] d;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "bclk", int'(bclk), 0);
    chk("R1", "fsync", int'(fsync), 0);
    chk("R1", "sdata", int'(sdata), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    rd_reg(3'd0, d); chk("R1", "ctrl", int'(d), 0);
    rd_reg(3'd1, d); chk("R1", "frame length", int'(d), 52);
    rd_reg(3'd2, d); chk("R1", "half divider", int'(d), 2);
    rd_reg(3'd3, d); chk("R1", "alarm", int'(d), 16);
    rd_reg(3'd4, d); chk("R1", "mask", int'(d), 0);
    rd_reg(3'd5, d); chk("R1", "level", int'(d), 0);
    // R11 readback
    wr_reg(3'd3, 16'd20); rd_reg(3'd3, d); chk("R11", "alarm readback", int'(d), 20);
    wr_reg(3'd3, 16'd16);
    wr_reg(3'd4, 16'd1);  rd_reg(3'd4, d); chk("R11", "mask readback", int'(d), 1);

    // Phase A: two words, enable, keep streaming while slots load
    push_word(16'hA5C3);
    push_word(16'h8000);
    rd_reg(3'd5, d); chk("R11", "level after 4 bytes", int'(d), 4);
    chk("R9", "irq while disabled", int'(irq), 0);
    chk("R10", "bclk idle", int'(bclk), 0);
    mon_on = 1'b1;
    wr_reg(3'd0, 16'd1);
    #1 chk("R9", "irq enabled below alarm", int'(irq), 1);
    push_word(16'h0001);
    push_word(16'h1234);
    push_word(16'hFFFF);
    push_word(16'h5A0F);
    rd_reg(3'd0, d); chk("R7", "no underrun while fed", int'(d), 1);
    while (exp_q.size() > 0) @(negedge clk);
    repeat (500) @(negedge clk);
    chk("R7", "zero slots seen", int'(zero_slots > 0), 1);
    rd_reg(3'd0, d); chk("R7", "underrun flag set", int'(d), 3);
    mon_on = 1'b0;
    wr_reg(3'd0, 16'd2);
    repeat (3) @(negedge clk);
    rd_reg(3'd0, d); chk("R7", "underrun cleared", int'(d), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bclk || fsync || sdata) begin
        chk("R10", "outputs idle", int'({bclk, fsync, sdata}), 0);
        break;
      end
    end
    chk("R10", "outputs idle end", int'({bclk, fsync, sdata}), 0);

    // Phase B: new geometry, FIFO filled to the top
    wr_reg(3'd1, 16'd50); exp_len = 50;
    wr_reg(3'd2, 16'd3);  exp_half = 3;
    for (int i = 0; i < 32; i++) push_word(16'((i * 16'h3C5) ^ 16'h9A00));
    @(negedge clk);
    chk("R8", "in_ready at full", int'(in_ready), 0);
    in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    in_valid = 1'b0;
    rd_reg(3'd5, d); chk("R8", "level held at 64", int'(d), 64);
    zero_slots = 0;
    mon_on = 1'b1;
    wr_reg(3'd0, 16'd1);
    #1 chk("R9", "irq off above alarm", int'(irq), 0);
    for (int i = 0; i < 12; i++) begin
      repeat (250) @(negedge clk);
      rd_reg(3'd5, d);
      chk("R9", "irq vs level", int'(irq), int'(d <= 16));
    end
    wr_reg(3'd4, 16'd0);
    #1 chk("R9", "irq masked", int'(irq), 0);
    while (exp_q.size() > 0) @(negedge clk);
    repeat (400) @(negedge clk);
    mon_on = 1'b0;
    wr_reg(3'd0, 16'd0);
    repeat (4) @(negedge clk);
    chk("R10", "idle after phase B", int'({bclk, fsync, sdata}), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule